// File: doc/BRIEF.md
# Two-Level MSI Interrupt Status Controller

This block gathers interrupt events for a PCIe root-port bridge and presents them to a processor through two status registers. Each register is read directly and cleared by writing ones. The local register holds one bit per independent local source. One of its bits, bit 28, is a summary bit that records that some MSI has arrived. The MSI register records which of 32 message numbers have been received.

Local sources deliver single-cycle event pulses. An MSI receive is a one-cycle valid pulse that carries a 5-bit message number. Each receive sets the bit for its message number and also sets the summary bit. The two registers clear independently, so software can clear the summary first and then scan the vectors without losing a later MSI.

A registered level interrupt goes to the processor whenever any local status bit is set. Register access uses a 32-bit enable/write/address port. The read data is registered.

Top module: `msi_irq_status`

## Requirements
- R1: A pulse on `local_evt[i]` sets local status bit i for every implemented source bit (default bits 15..0). Several bits may set in the same cycle.
- R2: A write with `reg_addr`=0 clears each local status bit whose write-data bit is 1. Bits written 0 keep their value.
- R3: `irq` becomes 1 one cycle after any local status bit is set. It becomes 0 one cycle after the last local status bit is cleared.
- R4: `msi_valid` with message number n sets MSI status bit n and local summary bit 28. Both are visible on the next cycle.
- R5: A write with `reg_addr`=1 clears each MSI status bit whose write-data bit is 1. It never clears summary bit 28.
- R6: An MSI that arrives after the summary bit was cleared sets it again, even while earlier MSI status bits are still pending.
- R7: When a set event and a write-one-to-clear hit the same bit in the same cycle, the bit ends set.
- R8: Unimplemented local bits (31..16 except 28) always read 0 and ignore events. `local_evt[28]` has no effect; only MSI receives set bit 28.
- R9: Both registers reset to 0. A read (`reg_en`=1, `reg_we`=0) returns the register's stored value before that cycle's updates on `reg_rdata` one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_evt | input | 32 | Local source event pulses, one per bit |
| msi_valid | input | 1 | MSI received this cycle |
| msi_num | input | 5 | Message number of the received MSI |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write-one-to-clear, 0 = read |
| reg_addr | input | 1 | 0 = local status, 1 = MSI status |
| reg_wdata | input | 32 | Clear mask for writes |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt to the processor |

## Verification
The bench targets three corner cases:

- **Re-arm race.** The summary bit is cleared while vectors are still pending, and then a new MSI arrives. A design that re-arms only when the MSI register is empty would leave the summary low, and the interrupt would be lost.
- **Same-cycle set and clear.** An event and a clear hit the same bit in the same cycle. A design that lets the clear win would silently drop the event.
- **Independent clears.** Clearing MSI bits must leave the summary bit alone. A design that couples the two registers would clear the summary too early.

The bench also confirms that unimplemented bits and event bit 28 stay inert. It checks the one-cycle `irq` latency on both edges. It checks that a read issued in the same cycle as an event returns the old value.

// File: rtl/msi_irq_status.sv
module msi_irq_status #(
  parameter int              DW       = 32,
  parameter int              NUM_MSI  = 32,
  parameter int              SUM_BIT  = 28,
  parameter logic [DW-1:0]   SRC_MASK = 32'h0000_FFFF,
  localparam int             NW       = $clog2(NUM_MSI)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] local_evt,
  input  logic          msi_valid,
  input  logic [NW-1:0] msi_num,
  input  logic          reg_en,
  input  logic          reg_we,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);

  localparam logic [DW-1:0] SUM_ONE    = DW'(1) << SUM_BIT;
  localparam logic [DW-1:0] SRC_ONLY   = SRC_MASK & ~SUM_ONE;
  localparam logic [DW-1:0] LOCAL_IMPL = SRC_ONLY | SUM_ONE;

  logic [DW-1:0]      local_q, local_d, local_set, local_clr;
  logic [NUM_MSI-1:0] msi_q, msi_d, msi_hit, msi_clr;
  logic               wr_local, wr_msi;

  assign wr_local  = reg_en & reg_we & ~reg_addr;
  assign wr_msi    = reg_en & reg_we &  reg_addr;

  assign local_set = (local_evt & SRC_ONLY) | (msi_valid ? SUM_ONE : '0);
  assign local_clr = wr_local ? reg_wdata : '0;
  assign local_d   = ((local_q & ~local_clr) | local_set) & LOCAL_IMPL;

  assign msi_hit   = msi_valid ? (NUM_MSI'(1) << msi_num) : '0;
  assign msi_clr   = wr_msi ? reg_wdata[NUM_MSI-1:0] : '0;
  assign msi_d     = (msi_q & ~msi_clr) | msi_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      local_q   <= '0;
      msi_q     <= '0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      local_q <= local_d;
      msi_q   <= msi_d;
      irq     <= |local_q;
      if (reg_en && !reg_we)
        reg_rdata <= reg_addr ? DW'(msi_q) : local_q;
    end
  end

  a_r4_vector_set: assert property (@(posedge clk) disable iff (!rst_n)
    msi_valid |=> msi_q[$past(msi_num)]);

  a_r4_summary_set: assert property (@(posedge clk) disable iff (!rst_n)
    msi_valid |=> local_q[SUM_BIT]);

  a_r5_msi_clear_keeps_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_msi && local_q[SUM_BIT]) |=> local_q[SUM_BIT]);

  a_r3_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|local_q) |=> irq);

  a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && wr_local && reg_wdata[SUM_BIT]) |=> local_q[SUM_BIT]);

endmodule

// File: tb/tb_msi_irq_status.sv
module tb_msi_irq_status;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [31:0] local_evt = '0, reg_wdata = '0, reg_rdata;
  logic        msi_valid = 0, reg_en = 0, reg_we = 0, reg_addr = 0, irq;
  logic [4:0]  msi_num = '0;

  int checks = 0, fails = 0;
  logic [31:0] rv;

  msi_irq_status dut (.clk, .rst_n, .local_evt, .msi_valid, .msi_num,
    .reg_en, .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .irq);

  always #(CLK_PERIOD/2) clk = ~clk;

  // {local_evt, msi_valid, msi_num, expected local, expected msi}, cumulative
  localparam logic [101:0] VEC [5] = '{
    {32'h0000_0005, 1'b0, 5'd0,  32'h0000_0005, 32'h0000_0000},
    {32'hFFFF_0000, 1'b0, 5'd0,  32'h0000_0005, 32'h0000_0000},
    {32'h0000_0000, 1'b1, 5'd3,  32'h1000_0005, 32'h0000_0008},
    {32'h0000_8000, 1'b1, 5'd31, 32'h1000_8005, 32'h8000_0008},
    {32'h0000_0000, 1'b1, 5'd0,  32'h1000_8005, 32'h8000_0009}
  };

  task automatic check(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [31:0] v);
    @(negedge clk); reg_en = 1; reg_we = 0; reg_addr = a;
    @(negedge clk); reg_en = 0; v = reg_rdata;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_en = 0; reg_we = 0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [31:0] e, input logic v, input logic [4:0] n);
    @(negedge clk); local_evt = e; msi_valid = v; msi_num = n;
    @(negedge clk); local_evt = '0; msi_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset values
    check("R9 irq reset", {31'd0, irq}, 32'd0);
    rd(0, rv); check("R9 local reset", rv, 32'h0);
    rd(1, rv); check("R9 msi reset", rv, 32'h0);

    // R1 R4 R8 table
    for (int i = 0; i < 5; i++) begin
      pulse(VEC[i][101:70], VEC[i][69], VEC[i][68:64]);
      rd(0, rv); check("R1/R8 local table", rv, VEC[i][63:32]);
      rd(1, rv); check("R4 msi table", rv, VEC[i][31:0]);
    end
    check("R3 irq high", {31'd0, irq}, 32'd1);

    // R2 clear bit 0, zeros leave others
    wr(0, 32'h0000_0001);
    rd(0, rv); check("R2 w1c local", rv, 32'h1000_8004);

    // R5 clearing msi keeps summary
    wr(1, 32'h8000_0000);
    rd(1, rv); check("R5 msi cleared", rv, 32'h0000_0009);
    rd(0, rv); check("R5 summary kept", rv, 32'h1000_8004);

    // R6 re-arm after summary clear with vectors pending
    wr(0, 32'h1000_0000);
    rd(0, rv); check("R6 summary cleared", rv, 32'h0000_8004);
    pulse(32'h0, 1'b1, 5'd5);
    rd(0, rv); check("R6 summary re-armed", rv, 32'h1000_8004);
    rd(1, rv); check("R6 msi pending", rv, 32'h0000_0029);

    // R7 set wins: local bit 2 and msi bit 0
    @(negedge clk); local_evt = 32'h4; reg_en = 1; reg_we = 1; reg_addr = 0; reg_wdata = 32'h4;
    @(negedge clk); local_evt = '0; msi_valid = 1; msi_num = 5'd0; reg_addr = 1; reg_wdata = 32'h1;
    @(negedge clk); msi_valid = 0; reg_en = 0; reg_we = 0; reg_wdata = '0;
    rd(0, rv); check("R7 local set wins", rv, 32'h1000_8004);
    rd(1, rv); check("R7 msi set wins", rv, 32'h0000_0029);

    // R9 read concurrent with event returns old value
    @(negedge clk); local_evt = 32'h2; reg_en = 1; reg_we = 0; reg_addr = 0;
    @(negedge clk); local_evt = '0; reg_en = 0; rv = reg_rdata;
    check("R9 read old value", rv, 32'h1000_8004);
    rd(0, rv); check("R9 read new value", rv, 32'h1000_8006);

    // R3 irq falls one cycle after last clear, rises one cycle after set
    wr(1, 32'hFFFF_FFFF);
    wr(0, 32'hFFFF_FFFF);
    check("R3 irq latency fall", {31'd0, irq}, 32'd1);
    @(negedge clk); check("R3 irq low", {31'd0, irq}, 32'd0);
    rd(0, rv); check("R2 all cleared", rv, 32'h0);
    pulse(32'h0000_0002, 1'b0, 5'd0);
    check("R3 irq latency rise", {31'd0, irq}, 32'd0);
    @(negedge clk); check("R3 irq rise", {31'd0, irq}, 32'd1);

    // R8 event on bit 28 alone does nothing
    wr(0, 32'hFFFF_FFFF);
    pulse(32'h1000_0000, 1'b0, 5'd0);
    rd(0, rv); check("R8 bit28 event ignored", rv, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule